// File: doc/BRIEF.md
# Floating-Point Compare with Condition History

This block compares two single-precision IEEE 754 operands in one cycle. It sorts their relation into one of four classes: greater, less, equal or unordered. A 5-bit condition mask then turns that class into a single true/false result bit. The result is stored in one of two ways. A nonzero target selector writes it into an indexed target bit. A zero selector pushes it through a condition history: the current main flag moves into the newest history slot, and the main flag takes the new result.

The block also reports an invalid-operation indication for each compare. A signaling compare (mask bit 0 set) raises it when either operand is any NaN. A quiet compare raises it only when an operand is a signaling NaN. All outputs are registered and change on the clock edge that samples the valid strobe. A branch or conditional-move unit would read the main flag, the history and the target bits.

Top module: `fcmp_queue`

## Requirements
- R1: While `rstN` is low, and after it is released until the first compare, `cmpFlag`, `cmpHistory`, `cmpTargets`, `relation` and `invalidFlag` are all zero.
- R2: A NaN is an operand with exponent bits [30:23] all ones and a nonzero fraction [22:0]. If either operand is a NaN, the relation is unordered. Positive and negative zero compare equal.
- R3: For ordered, non-zero-pair operands the relation follows sign-magnitude order of the 32-bit encodings. A positive value is greater than a negative one. Among negatives, the larger magnitude is less. This order includes infinities and subnormals.
- R4: The result bit is `condSel[4]` for greater, `condSel[3]` for less, `condSel[2]` for equal and `condSel[1]` for unordered.
- R5: `invalidFlag` is 1 on the cycle after a compare when either operand is a signaling NaN (fraction bit 22 clear). It is also 1 when `condSel[0]` is 1 and either operand is any NaN. Otherwise it is 0.
- R6: A compare with `targetSel` = k ≠ 0 writes the result into `cmpTargets[k-1]`. No other target bit, the main flag and the history stay unchanged.
- R7: A compare with `targetSel` = 0 moves `cmpHistory[i]` to `cmpHistory[i+1]` and the old `cmpFlag` into `cmpHistory[0]`, then loads `cmpFlag` with the result. The oldest history bit is discarded. Target bits stay unchanged.
- R8: A cycle with `valid` low changes no stored bit, and gives `relation` = 0 and `invalidFlag` = 0 on the next cycle, whatever the other inputs are.
- R9: On the cycle after a compare, `relation` has exactly one bit set, encoded as [3] greater, [2] less, [1] equal, [0] unordered.
- R10: All results of a compare appear on the outputs exactly one clock cycle after `valid` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| valid | input | 1 | Compare request for this cycle |
| opA | input | 32 | First operand, single precision |
| opB | input | 32 | Second operand, single precision |
| condSel | input | 5 | Relation mask [4:1] and signaling-compare bit [0] |
| targetSel | input | SEL_W (3) | 0 selects history push, k selects target bit k-1 |
| cmpFlag | output | 1 | Main compare flag |
| cmpHistory | output | QUEUE_DEPTH (11) | Older flag values, index 0 newest |
| cmpTargets | output | 2**SEL_W-1 (7) | Individually addressed result bits |
| relation | output | 4 | One-hot relation of the last compare |
| invalidFlag | output | 1 | Invalid-operation indication of the last compare |

## Verification
The hardest state to reach is the drop at the end of the history. It shows only after more than QUEUE_DEPTH queued compares in a row with a known bit pattern. The stimulus therefore runs a run of queued compares longer than the history. Each one uses a fixed greater relation, and the mask is chosen per step so that a chosen bit pattern is shifted in. Quiet-versus-signaling invalid behaviour needs both NaN kinds paired with both mask settings. The vector table crosses them. It mixes targeted and queued compares, so each writes only its own bits while a bench model tracks all stored state.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int FP_W   = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int REL_W  = 4;

  // relation vector bit positions; condSel bit index is position + 1
  localparam int REL_UNORD = 0;
  localparam int REL_EQ    = 1;
  localparam int REL_LT    = 2;
  localparam int REL_GT    = 3;

  typedef struct packed {
    logic isNan;
    logic isSnan;
    logic isZero;
  } opClass_t;

  typedef struct packed {
    logic capture;
    logic shiftQueue;
    logic writeTarget;
  } ctrlStrobe_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
(
  input  logic [FP_W-1:0] operand,
  output opClass_t        opClass
);
  logic expAllOnes;
  logic fracNonZero;

  always_comb begin
    expAllOnes      = &operand[FP_W-2 -: EXP_W];
    fracNonZero     = |operand[FRAC_W-1:0];
    opClass.isNan   = expAllOnes && fracNonZero;
    opClass.isSnan  = expAllOnes && fracNonZero && !operand[FRAC_W-1];
    opClass.isZero  = ~|operand[FP_W-2:0];
  end
endmodule

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int NUM_TGT = (1 << SEL_W) - 1
) (
  input  logic               valid,
  input  logic [SEL_W-1:0]   targetSel,
  output ctrlStrobe_t        strobe,
  output logic [NUM_TGT-1:0] targetHit
);
  logic selZero;

  always_comb begin
    selZero            = (targetSel == '0);
    strobe.capture     = valid;
    strobe.shiftQueue  = valid && selZero;
    strobe.writeTarget = valid && !selZero;
  end

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_hit
    assign targetHit[i] = strobe.writeTarget && (targetSel == SEL_W'(i + 1));
  end
endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int SEL_W       = 3,
  parameter int QUEUE_DEPTH = 11,
  localparam int NUM_TGT    = (1 << SEL_W) - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FP_W-1:0]    opA,
  input  logic [FP_W-1:0]    opB,
  input  opClass_t           classA,
  input  opClass_t           classB,
  input  logic [4:0]         condSel,
  input  ctrlStrobe_t        strobe,
  input  logic [NUM_TGT-1:0] targetHit,
  output logic                   cmpFlag,
  output logic [QUEUE_DEPTH-1:0] cmpHistory,
  output logic [NUM_TGT-1:0]     cmpTargets,
  output logic [REL_W-1:0]       relation,
  output logic                   invalidFlag
);
  logic [REL_W-1:0]  relNext;
  logic              resultBit;
  logic              invNext;
  logic              signA;
  logic              signB;
  logic [FP_W-2:0]   magA;
  logic [FP_W-2:0]   magB;
  logic              magGreater;

  always_comb begin
    signA      = opA[FP_W-1];
    signB      = opB[FP_W-1];
    magA       = opA[FP_W-2:0];
    magB       = opB[FP_W-2:0];
    magGreater = magA > magB;
    relNext    = '0;
    if (classA.isNan || classB.isNan) begin
      relNext[REL_UNORD] = 1'b1;
    end else if (classA.isZero && classB.isZero) begin
      relNext[REL_EQ] = 1'b1;
    end else if (signA != signB) begin
      if (signA) relNext[REL_LT] = 1'b1;
      else       relNext[REL_GT] = 1'b1;
    end else if (magA == magB) begin
      relNext[REL_EQ] = 1'b1;
    end else if (magGreater ^ signA) begin
      relNext[REL_GT] = 1'b1;
    end else begin
      relNext[REL_LT] = 1'b1;
    end
    resultBit = |(condSel[4:1] & relNext);
    invNext   = classA.isSnan || classB.isSnan ||
                (condSel[0] && (classA.isNan || classB.isNan));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relation    <= '0;
      invalidFlag <= 1'b0;
    end else begin
      relation    <= strobe.capture ? relNext : '0;
      invalidFlag <= strobe.capture && invNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpFlag <= 1'b0;
    end else if (strobe.shiftQueue) begin
      cmpFlag <= resultBit;
    end
  end

  if (QUEUE_DEPTH > 1) begin : g_deep
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpHistory <= '0;
      end else if (strobe.shiftQueue) begin
        cmpHistory <= {cmpHistory[QUEUE_DEPTH-2:0], cmpFlag};
      end
    end
  end else begin : g_single
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpHistory <= '0;
      end else if (strobe.shiftQueue) begin
        cmpHistory <= cmpFlag;
      end
    end
  end

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpTargets[i] <= 1'b0;
      end else if (targetHit[i]) begin
        cmpTargets[i] <= resultBit;
      end
    end
  end
endmodule

// File: rtl/fcmp_queue.sv
module fcmp_queue
  import fcmp_pkg::*;
#(
  parameter int SEL_W       = 3,
  parameter int QUEUE_DEPTH = 11,
  localparam int NUM_TGT    = (1 << SEL_W) - 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   valid,
  input  logic [31:0]            opA,
  input  logic [31:0]            opB,
  input  logic [4:0]             condSel,
  input  logic [SEL_W-1:0]       targetSel,
  output logic                   cmpFlag,
  output logic [QUEUE_DEPTH-1:0] cmpHistory,
  output logic [NUM_TGT-1:0]     cmpTargets,
  output logic [3:0]             relation,
  output logic                   invalidFlag
);
  opClass_t    classes [2];
  ctrlStrobe_t strobe;
  logic [NUM_TGT-1:0] targetHit;
  logic [FP_W-1:0]    operands [2];

  assign operands[0] = opA;
  assign operands[1] = opB;

  for (genvar k = 0; k < 2; k++) begin : g_cls
    fcmp_classify u_cls (
      .operand (operands[k]),
      .opClass (classes[k])
    );
  end

  fcmp_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .valid     (valid),
    .targetSel (targetSel),
    .strobe    (strobe),
    .targetHit (targetHit)
  );

  fcmp_datapath #(.SEL_W(SEL_W), .QUEUE_DEPTH(QUEUE_DEPTH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .opA         (opA),
    .opB         (opB),
    .classA      (classes[0]),
    .classB      (classes[1]),
    .condSel     (condSel),
    .strobe      (strobe),
    .targetHit   (targetHit),
    .cmpFlag     (cmpFlag),
    .cmpHistory  (cmpHistory),
    .cmpTargets  (cmpTargets),
    .relation    (relation),
    .invalidFlag (invalidFlag)
  );
endmodule

// File: rtl/fcmp_queue_chk.sv
module fcmp_queue_chk #(
  parameter int SEL_W       = 3,
  parameter int QUEUE_DEPTH = 11,
  localparam int NUM_TGT    = (1 << SEL_W) - 1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   valid,
  input logic [31:0]            opA,
  input logic [31:0]            opB,
  input logic [4:0]             condSel,
  input logic [SEL_W-1:0]       targetSel,
  input logic                   cmpFlag,
  input logic [QUEUE_DEPTH-1:0] cmpHistory,
  input logic [NUM_TGT-1:0]     cmpTargets,
  input logic [3:0]             relation,
  input logic                   invalidFlag
);
  logic nanA, nanB, bothZero, anyNan;
  assign nanA     = (&opA[30:23]) && (|opA[22:0]);
  assign nanB     = (&opB[30:23]) && (|opB[22:0]);
  assign anyNan   = nanA || nanB;
  assign bothZero = (opA[30:0] == 31'd0) && (opB[30:0] == 31'd0);

  // R9
  one_relation_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> $countones(relation) == 1);

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> $stable(cmpFlag) && $stable(cmpHistory) && $stable(cmpTargets)
               && relation == 4'd0 && !invalidFlag);

  // R2
  nan_unordered_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid && anyNan |=> relation == 4'b0001);

  // R2
  zero_equal_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid && bothZero |=> relation == 4'b0010);

  // R3
  sign_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid && !anyNan && !bothZero && (opA[31] != opB[31])
    |=> relation == ($past(opA[31]) ? 4'b0100 : 4'b1000));

  // R5
  signaling_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid && condSel[0] && anyNan |=> invalidFlag);

  // R6
  target_isolation_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid && targetSel != '0 |=> $stable(cmpFlag) && $stable(cmpHistory));

  // R7
  queue_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid && targetSel == '0 |=> cmpHistory[0] == $past(cmpFlag)
                                 && $stable(cmpTargets));

  // R4
  result_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid && targetSel == '0 |=> cmpFlag == |($past(condSel[4:1]) & relation));
endmodule

bind fcmp_queue fcmp_queue_chk #(.SEL_W(SEL_W), .QUEUE_DEPTH(QUEUE_DEPTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .valid       (valid),
  .opA         (opA),
  .opB         (opB),
  .condSel     (condSel),
  .targetSel   (targetSel),
  .cmpFlag     (cmpFlag),
  .cmpHistory  (cmpHistory),
  .cmpTargets  (cmpTargets),
  .relation    (relation),
  .invalidFlag (invalidFlag)
);

// File: tb/fcmp_queue_bench.sv
module fcmp_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SEL_W      = 3;
  localparam int QD         = 11;
  localparam int NT         = (1 << SEL_W) - 1;

  localparam logic [31:0] P1   = 32'h3F800000;
  localparam logic [31:0] P2   = 32'h40000000;
  localparam logic [31:0] N1   = 32'hBF800000;
  localparam logic [31:0] N2   = 32'hC0000000;
  localparam logic [31:0] PZ   = 32'h00000000;
  localparam logic [31:0] NZ   = 32'h80000000;
  localparam logic [31:0] PINF = 32'h7F800000;
  localparam logic [31:0] NINF = 32'hFF800000;
  localparam logic [31:0] QNAN = 32'h7FC00000;
  localparam logic [31:0] SNAN = 32'h7F800001;
  localparam logic [31:0] PDEN = 32'h00000001;
  localparam logic [31:0] NDEN = 32'h80000001;

  localparam logic [3:0] GT = 4'b1000;
  localparam logic [3:0] LT = 4'b0100;
  localparam logic [3:0] EQ = 4'b0010;
  localparam logic [3:0] UN = 4'b0001;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  cond;
    logic [2:0]  sel;
    logic [3:0]  rel;
    logic        inv;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{P2,   P1,   5'b10000, 3'd1, GT, 1'b0},
    '{P1,   P2,   5'b01000, 3'd2, LT, 1'b0},
    '{N1,   N2,   5'b10000, 3'd0, GT, 1'b0},
    '{N2,   N1,   5'b01000, 3'd3, LT, 1'b0},
    '{PZ,   NZ,   5'b00100, 3'd0, EQ, 1'b0},
    '{N1,   P1,   5'b10000, 3'd4, LT, 1'b0},
    '{PINF, P2,   5'b10000, 3'd5, GT, 1'b0},
    '{NINF, PDEN, 5'b01000, 3'd0, LT, 1'b0},
    '{QNAN, P1,   5'b00010, 3'd6, UN, 1'b0},
    '{QNAN, P1,   5'b00011, 3'd7, UN, 1'b1},
    '{P1,   SNAN, 5'b00010, 3'd0, UN, 1'b1},
    '{P1,   P1,   5'b11011, 3'd1, EQ, 1'b0},
    '{PDEN, PZ,   5'b10000, 3'd2, GT, 1'b0},
    '{NZ,   NDEN, 5'b10001, 3'd0, GT, 1'b0},
    '{SNAN, QNAN, 5'b11100, 3'd3, UN, 1'b1},
    '{P2,   P2,   5'b11011, 3'd0, EQ, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic valid = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [4:0]  condSel = '0;
  logic [SEL_W-1:0] targetSel = '0;
  logic          cmpFlag;
  logic [QD-1:0] cmpHistory;
  logic [NT-1:0] cmpTargets;
  logic [3:0]    relation;
  logic          invalidFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic          expFlag;
  logic [QD-1:0] expHist;
  logic [NT-1:0] expTgt;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcmp_queue #(.SEL_W(SEL_W), .QUEUE_DEPTH(QD)) u_fcmp_queue (
    .clk(clk), .rstN(rstN), .valid(valid), .opA(opA), .opB(opB),
    .condSel(condSel), .targetSel(targetSel), .cmpFlag(cmpFlag),
    .cmpHistory(cmpHistory), .cmpTargets(cmpTargets),
    .relation(relation), .invalidFlag(invalidFlag)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkState(string req);
    check(req, "cmpFlag", 64'(cmpFlag), 64'(expFlag));
    check(req, "cmpHistory", 64'(cmpHistory), 64'(expHist));
    check(req, "cmpTargets", 64'(cmpTargets), 64'(expTgt));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // one compare; outputs sampled at the negedge after the capturing posedge (R10)
  task automatic runOp(logic [31:0] a, logic [31:0] b, logic [4:0] cond,
                       logic [SEL_W-1:0] sel, logic [3:0] rel, logic inv, string req);
    logic res;
    @(negedge clk);
    opA = a; opB = b; condSel = cond; targetSel = sel; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    res = |(cond[4:1] & rel);
    if (sel == '0) begin
      expHist = {expHist[QD-2:0], expFlag};
      expFlag = res;
    end else begin
      expTgt[sel-1] = res;
    end
    check(req, "relation", 64'(relation), 64'(rel));
    check("R9", "relation one-hot count", 64'($countones(relation)), 64'd1);
    check("R5", "invalidFlag", 64'(invalidFlag), 64'(inv));
    checkState(sel == '0 ? "R7" : "R6");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    expFlag = 1'b0; expHist = '0; expTgt = '0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    checkState("R1");
    check("R1", "relation", 64'(relation), 64'd0);
    check("R1", "invalidFlag", 64'(invalidFlag), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkState("R1");

    // table walk: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      runOp(VECS[i].a, VECS[i].b, VECS[i].cond, VECS[i].sel,
            VECS[i].rel, VECS[i].inv, "R2/R3 table");
    end

    // R4: each relation routed to its own mask bit only
    runOp(P2, P1, 5'b01110, 3'd0, GT, 1'b0, "R4 gt masked");
    check("R4", "flag gt masked", 64'(cmpFlag), 64'd0);
    runOp(QNAN, QNAN, 5'b00010, 3'd0, UN, 1'b0, "R4 unord");
    check("R4", "flag unord", 64'(cmpFlag), 64'd1);

    // R7: queue run longer than the history, oldest bits fall off
    for (int k = 0; k < QD + 3; k++) begin
      logic bitv;
      bitv = k[0] ^ k[1];
      runOp(P2, P1, bitv ? 5'b10000 : 5'b01111, 3'd0, GT, 1'b0, "R7 queue");
    end
    check("R7", "history after overflow", 64'(cmpHistory), 64'(expHist));

    // R6: targeted write leaves flag and history alone
    runOp(P1, P2, 5'b01000, 3'd7, LT, 1'b0, "R6 target7");
    check("R6", "target7 bit", 64'(cmpTargets[6]), 64'd1);

    // R8: idle cycle with live-looking inputs changes nothing
    @(negedge clk);
    opA = SNAN; opB = QNAN; condSel = 5'b11111; targetSel = '0; valid = 1'b0;
    @(negedge clk);
    checkState("R8");
    check("R8", "relation idle", 64'(relation), 64'd0);
    check("R8", "invalidFlag idle", 64'(invalidFlag), 64'd0);
    targetSel = 3'd2;
    @(negedge clk);
    checkState("R8");

    // R1: reset in mid run clears everything
    rstN = 1'b0;
    @(negedge clk);
    expFlag = 1'b0; expHist = '0; expTgt = '0;
    checkState("R1");
    check("R1", "relation after reset", 64'(relation), 64'd0);
    rstN = 1'b1;
    runOp(NINF, PINF, 5'b01000, 3'd0, LT, 1'b0, "R3 after reset");

    finish();
  end
endmodule